// File: doc/BRIEF.md
# Fractional Core and Cache Clock-Enable Generator

This block turns two small configuration codes into single-cycle enable pulses on a fast reference clock. Downstream logic uses these pulses to step a core domain and a cache domain at a programmed fraction of the reference rate. A 4-bit ratio code picks a multiplier from a fixed table. A 4-bit trim code removes between zero and eight pulses out of every sixteen. Multipliers are held internally as doubled integers, so x1.5 is stored as 3.

A phase accumulator of `ACC_W` bits adds the doubled multiplier on every reference cycle. Each carry out of the accumulator is a candidate pulse. Candidates are counted in groups of sixteen, and the trim code suppresses some of them, spread evenly through the group. Both codes are written through a simple write port and can be read back unchanged. They become active only when a group of sixteen candidates ends. The core enable rate is `ref * ratio * (1 - trim/16) / 2^(ACC_W-1)`. The block also reports the active effective ratio `ratio * (1 - trim/16)` as an unsigned number with 5 fractional bits.

Top module: `clkEnGen`

## Requirements
- R1: After reset, `coreEn` and `cacheEn` are 0, the ratio code reads back as 1, the trim code reads back as 0, and `effRatio` is 48 (x1.5 in 5-bit fraction).
- R2: A write with `wrSel`=0 stores `wrData` as the ratio code, and a write with `wrSel`=1 stores it as the trim code. From the next cycle, `rdData` returns the stored 4-bit value unchanged, selected by `rdSel` (0 = ratio code, 1 = trim code).
- R3: The defined ratio codes map to these doubled multipliers: 1→3, 3→6, 4→8, 5→12, 6→16, 7→24, 8→32, 9→36, 10→24, 12→9, 13→18, 14→32, 15→36. Over any 2^(ACC_W+4) consecutive reference cycles with fixed active codes, exactly 16×(doubled multiplier) candidates occur.
- R4: Ratio codes 0, 2 and 11 behave exactly like code 1 (x1.5).
- R5: Within each group, candidate k (k = 0..15) is suppressed when ((k×trim) mod 16) + trim ≥ 16. Every other candidate produces a one-cycle `coreEn` pulse in the cycle after the candidate.
- R6: A trim code of 9 or more acts as 0.
- R7: Written codes take effect only after the sixteenth candidate of the current group. Until then, `effRatio` and the pulse pattern keep the previous codes.
- R8: `cacheEn` is high only together with `coreEn`. For active ratio codes 8, 9 and 10 it marks only the first, third, fifth and later odd-numbered core pulses, counted since reset. For every other code it equals `coreEn`.
- R9: `effRatio` equals the doubled multiplier × (16 − effective trim) of the active codes, which is the ratio × (1 − trim/16) with 5 fractional bits.
- R10: With `ACC_W` ≥ 7, `coreEn` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one code |
| wrSel | input | 1 | Write target: 0 ratio code, 1 trim code |
| wrData | input | 4 | Code value to write |
| rdSel | input | 1 | Readback select: 0 ratio code, 1 trim code |
| rdData | output | 4 | Stored code selected by `rdSel` |
| coreEn | output | 1 | Core clock-enable pulse |
| cacheEn | output | 1 | Cache clock-enable pulse |
| effRatio | output | 11 | Active effective ratio, 5 fractional bits |

## Verification
On every cycle, the assertions check four things: core pulses never touch each other, cache pulses are a subset of core pulses, a written code is visible on readback in the next cycle, and `effRatio` changes only directly after a candidate.

The bench's scenarios cover the rest, using a cycle-accurate behavioural model plus pulse counts over full accumulator periods. That covers the multiplier table, the fallback of undefined codes, where suppressed pulses fall inside a group, trim values that act as zero, the half-rate cache pattern, and codes held back until a group ends.

// File: rtl/clkEnGenPkg.sv
package clkEnGenPkg;
  localparam int CODE_W    = 4;
  localparam int GROUP_LEN = 16;
  localparam int GROUP_W   = $clog2(GROUP_LEN);
  localparam int RATIO_W   = 6;
  localparam int MAX_TRIM  = 8;

  typedef struct packed {
    logic              load;
    logic              suppress;
    logic [CODE_W-1:0] nextMult;
    logic [CODE_W-1:0] actDiv;
  } ctlStrobe_t;

  // Doubled multiplier per ratio code; undefined codes use the x1.5 entry.
  function automatic logic [RATIO_W-1:0] ratioX2(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd3:    r = 6'd6;
      4'd4:    r = 6'd8;
      4'd5:    r = 6'd12;
      4'd6:    r = 6'd16;
      4'd7:    r = 6'd24;
      4'd8:    r = 6'd32;
      4'd9:    r = 6'd36;
      4'd10:   r = 6'd24;
      4'd12:   r = 6'd9;
      4'd13:   r = 6'd18;
      4'd14:   r = 6'd32;
      4'd15:   r = 6'd36;
      default: r = 6'd3;
    endcase
    return r;
  endfunction

  function automatic logic halfCache(input logic [CODE_W-1:0] code);
    return (code == 4'd8) || (code == 4'd9) || (code == 4'd10);
  endfunction

  function automatic logic [CODE_W-1:0] cleanDiv(input logic [CODE_W-1:0] d);
    return (d > CODE_W'(MAX_TRIM)) ? '0 : d;
  endfunction
endpackage

// File: rtl/clkEnCtrl.sv
module clkEnCtrl
  import clkEnGenPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [CODE_W-1:0] wrData,
  input  logic              rdSel,
  input  logic              cand,
  output logic [CODE_W-1:0] rdData,
  output ctlStrobe_t        ctl
);
  logic [CODE_W-1:0]  shadowMult;
  logic [CODE_W-1:0]  shadowDiv;
  logic [CODE_W-1:0]  actDiv;
  logic [GROUP_W-1:0] grpIdx;
  logic [GROUP_W-1:0] grpSum;
  logic [GROUP_W:0]   spreadSum;
  logic               atLast;

  // Running sum of the trim code; a carry out of the group width marks a slot to drop.
  assign spreadSum = {1'b0, grpSum} + (GROUP_W+1)'(actDiv);
  assign atLast    = (grpIdx == GROUP_W'(GROUP_LEN - 1));

  always_comb begin
    ctl.load     = cand & atLast;
    ctl.suppress = cand & spreadSum[GROUP_W];
    ctl.nextMult = shadowMult;
    ctl.actDiv   = actDiv;
  end

  assign rdData = rdSel ? shadowDiv : shadowMult;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowMult <= CODE_W'(1);
      shadowDiv  <= '0;
    end else if (wrEn) begin
      if (wrSel) shadowDiv  <= wrData;
      else       shadowMult <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actDiv <= '0;
      grpIdx <= '0;
      grpSum <= '0;
    end else if (cand) begin
      grpIdx <= grpIdx + GROUP_W'(1);
      if (atLast) begin
        actDiv <= cleanDiv(shadowDiv);
        grpSum <= '0;
      end else begin
        grpSum <= spreadSum[GROUP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/clkEnPath.sv
module clkEnPath
  import clkEnGenPkg::*;
#(
  parameter int ACC_W = 7,
  localparam int EFF_W = RATIO_W + GROUP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  output logic             cand,
  output logic             coreEn,
  output logic             cacheEn,
  output logic [EFF_W-1:0] effRatio
);
  logic [CODE_W-1:0]  actMult;
  logic [RATIO_W-1:0] actRx2;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W:0]     accSum;
  logic [GROUP_W:0]   keptSlots;
  logic               keep;
  logic               halfPhase;
  logic               halfMode;

  assign actRx2    = ratioX2(actMult);
  assign halfMode  = halfCache(actMult);
  assign accSum    = {1'b0, acc} + (ACC_W+1)'(actRx2);
  assign cand      = accSum[ACC_W];
  assign keep      = cand & ~ctl.suppress;
  assign keptSlots = (GROUP_W+1)'(GROUP_LEN) - (GROUP_W+1)'(ctl.actDiv);
  assign effRatio  = EFF_W'(actRx2) * EFF_W'(keptSlots);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      actMult   <= CODE_W'(1);
      coreEn    <= 1'b0;
      cacheEn   <= 1'b0;
      halfPhase <= 1'b0;
    end else begin
      acc     <= accSum[ACC_W-1:0];
      coreEn  <= keep;
      cacheEn <= keep & (~halfMode | ~halfPhase);
      if (keep)     halfPhase <= ~halfPhase;
      if (ctl.load) actMult   <= ctl.nextMult;
    end
  end
endmodule

// File: rtl/clkEnGen.sv
module clkEnGen
  import clkEnGenPkg::*;
#(
  parameter int ACC_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [3:0]  wrData,
  input  logic        rdSel,
  output logic [3:0]  rdData,
  output logic        coreEn,
  output logic        cacheEn,
  output logic [10:0] effRatio
);
  ctlStrobe_t ctlBus;
  logic       candStrobe;

  clkEnCtrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .rdSel  (rdSel),
    .cand   (candStrobe),
    .rdData (rdData),
    .ctl    (ctlBus)
  );

  clkEnPath #(.ACC_W(ACC_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctlBus),
    .cand     (candStrobe),
    .coreEn   (coreEn),
    .cacheEn  (cacheEn),
    .effRatio (effRatio)
  );
endmodule

// File: rtl/clkEnGenChk.sv
module clkEnGenChk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        wrSel,
  input logic [3:0]  wrData,
  input logic        rdSel,
  input logic [3:0]  rdData,
  input logic        coreEn,
  input logic        cacheEn,
  input logic [10:0] effRatio,
  input logic        candStrobe
);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreEn |=> !coreEn);

  // R8
  cache_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cacheEn |-> coreEn);

  // R2
  mult_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrSel) |=> (rdSel || rdData == $past(wrData)));

  // R2
  div_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel) |=> (!rdSel || rdData == $past(wrData)));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(effRatio) |-> $past(candStrobe));
endmodule

bind clkEnGen clkEnGenChk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .rdSel      (rdSel),
  .rdData     (rdData),
  .coreEn     (coreEn),
  .cacheEn    (cacheEn),
  .effRatio   (effRatio),
  .candStrobe (candStrobe)
);

// File: tb/clkEnGen_bench.sv
module clkEnGen_bench;
  localparam int ACC_W = 7;
  localparam int MODV  = 1 << ACC_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [3:0]  wrData = 4'd0;
  logic        rdSel = 1'b0;
  logic [3:0]  rdData;
  logic        coreEn;
  logic        cacheEn;
  logic [10:0] effRatio;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int coreCnt = 0;
  int cacheCnt = 0;

  // behavioural model state
  int mShMult = 1, mShDiv = 0, mActMult = 1, mActDiv = 0;
  int mAcc = 0, mIdx = 0, mPhase = 0, pending = 0;
  int expCore = 0, expCache = 0;

  always #5 clk = ~clk;

  clkEnGen #(.ACC_W(ACC_W)) u_clkEnGen (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .coreEn(coreEn), .cacheEn(cacheEn),
    .effRatio(effRatio)
  );

  function automatic int rx2(input int code);
    case (code)
      3: return 6;   4: return 8;   5: return 12;  6: return 16;
      7: return 24;  8: return 32;  9: return 36;  10: return 24;
      12: return 9;  13: return 18; 14: return 32; 15: return 36;
      default: return 3;
    endcase
  endfunction

  function automatic bit isHalf(input int code);
    return code == 8 || code == 9 || code == 10;
  endfunction

  function automatic int effDiv(input int d);
    return (d >= 9) ? 0 : d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int r;
    bit cand;
    bit keepE;
    if (!rst_n) begin
      mShMult = 1; mShDiv = 0; mActMult = 1; mActDiv = 0;
      mAcc = 0; mIdx = 0; mPhase = 0; expCore = 0; expCache = 0; pending = 0;
    end else begin
      r = rx2(mActMult);
      cand = (mAcc + r) >= MODV;
      mAcc = (mAcc + r) % MODV;
      keepE = cand && !((((mIdx * mActDiv) % 16) + mActDiv) >= 16);
      expCore = keepE;
      expCache = keepE && (!isHalf(mActMult) || mPhase == 0);
      if (keepE) mPhase = 1 - mPhase;
      if (cand) begin
        if (mIdx == 15) begin
          mActMult = mShMult;
          mActDiv = effDiv(mShDiv);
          pending = 0;
        end
        mIdx = (mIdx + 1) % 16;
      end
      if (wrEn) begin
        if (wrSel) mShDiv = int'(wrData);
        else mShMult = int'(wrData);
        pending = 1;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R5 coreEn", int'(coreEn), expCore);
      chk("R8 cacheEn", int'(cacheEn), expCache);
      chk("R9 effRatio", int'(effRatio), rx2(mActMult) * (16 - mActDiv));
      chk("R2 rdData", int'(rdData), rdSel ? mShDiv : mShMult);
      if (coreEn) coreCnt++;
      if (cacheEn) cacheCnt++;
    end
  end

  task automatic writeReg(input bit sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = 4'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic scen(input string req, input int m, input int d);
    int kept;
    writeReg(1'b0, m);
    writeReg(1'b1, d);
    repeat (1500) @(negedge clk);
    coreCnt = 0; cacheCnt = 0;
    repeat (16 * MODV) @(negedge clk);
    kept = rx2(m) * (16 - effDiv(d));
    chk({req, " core count"}, coreCnt, kept);
    chk({req, " cache count"}, cacheCnt, isHalf(m) ? kept / 2 : kept);
    chk({req, " effRatio"}, int'(effRatio), kept);
  endtask

  initial begin : main
    int oldEff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 coreEn", int'(coreEn), 0);
    chk("R1 cacheEn", int'(cacheEn), 0);
    chk("R1 ratio code", int'(rdData), 1);
    chk("R1 effRatio", int'(effRatio), 48);
    rdSel = 1'b1; #1;
    chk("R1 trim code", int'(rdData), 0);
    // R2 raw readback of an out-of-range trim
    writeReg(1'b1, 13);
    #1 chk("R2 trim readback", int'(rdData), 13);
    rdSel = 1'b0;
    // R7 new code held until the group ends
    oldEff = int'(effRatio);
    writeReg(1'b0, 9);
    #1 chk("R2 ratio readback", int'(rdData), 9);
    if (pending != 0) chk("R7 held effRatio", int'(effRatio), oldEff);
    scen("R3 x6", 5, 0);
    scen("R3 x18 trim3", 9, 3);
    scen("R4 code2", 2, 0);
    scen("R4 code11 trim2", 11, 2);
    scen("R5 x4.5 trim4", 12, 4);
    scen("R5 x12 trim8", 7, 8);
    scen("R6 trim12", 6, 12);
    scen("R6 trim9", 10, 9);
    scen("R8 half x16", 8, 1);
    scen("R8 full x16", 14, 0);
    scen("R10 x18", 15, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule